// File: doc/BRIEF.md
# Reference-Based Frequency Range Monitor

This block checks whether a clock-recovery loop runs near the rate set by a local reference. It runs on the recovered byte clock and treats that clock as the time base. The reference arrives as a level that changes once per reference period, so each change is one reference tick. The block counts these ticks over a fixed window of 4096 byte-clock cycles. It then compares the total with a band of ±1500 ppm around the count it expects. The expected count depends on how fast the reference runs. A reference at the character rate gives 4096 ticks per window, and a reference at half that rate gives 2048.

The block drives one control flag. While the flag is high, the recovery loop is held on the reference. A measured window that lands out of band raises the flag for the next window. At the end of that window the flag drops again, whatever that window measured, so the loop can retry on the incoming data. After reset the flag starts high and stays high until a window measures in band. As a result, lock after data returns can take up to one full window. Every window ends with a one-cycle strobe, and the verdict of that window is held on a separate output until the next window closes.

Top module: `freq_range_monitor`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, forceRef is 1, measDone is 0 and windowOk is 0.
- R2: A window lasts 4096 clock cycles. The first window starts at the first rising edge after reset is released. measDone is 1 for exactly one cycle, the cycle right after the last cycle of each window, and is 0 at all other times.
- R3: refToggle passes through a two-flop synchronizer. Each change of its level, rising or falling, counts as one tick. A level change within the last two cycles of a window is counted in the next window.
- R4: When halfRate is 0, a window is in band if its tick count lies between 4089 and 4103 inclusive (4096 ± 7). When halfRate is 1, it is in band if its count lies between 2044 and 2052 inclusive (2048 ± 4). windowOk shows the verdict of the last closed window, 1 meaning in band.
- R5: halfRate is read only in the last cycle of a window. A change to halfRate that is undone before that cycle has no effect on the verdict.
- R6: After reset, forceRef stays 1 through any number of out-of-band windows. It drops to 0 when the first in-band window closes.
- R7: While forceRef is 0, a window that closes out of band sets forceRef to 1 for exactly the next window.
- R8: When a window that was forced because of an out-of-band result closes, forceRef returns to 0, even if that window itself measured out of band.
- R9: forceRef and windowOk change only in the cycle in which measDone is 1.
- R10: Asserting reset in the middle of a window at once restores the R1 values and restarts window timing from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered byte clock. It is the time base for the window. |
| rstN | input | 1 | Asynchronous active-low reset. |
| refToggle | input | 1 | Reference level that changes once per reference period. It is asynchronous to clk. |
| halfRate | input | 1 | Reference rate select: 1 means half the character rate, 0 means the full character rate. |
| forceRef | output | 1 | High while the recovery loop must follow the reference. |
| measDone | output | 1 | One-cycle strobe when a window closes. |
| windowOk | output | 1 | Verdict of the last closed window: 1 means in band. |

## Verification
Each window is fed one of two steady tick patterns: a tick every cycle (full rate) or a tick every other cycle (half rate). Mid-window gaps or extra ticks then move the count by a known amount. Because of this, band edges such as 4089 against 4088 and 2052 against 2053 show whether the limits are inclusive and whether the tolerance was rounded up. Some windows pair a full-rate pattern with the half-rate select, or the reverse. These windows, together with a select that changes mid-window and is then restored, show whether halfRate is read only at the close of a window. Sequences of out-of-band windows after reset, and again after a release, separate the reset hold from the one-window forced retry. A constrained-random run of offsets near both band edges finishes the test.

// File: rtl/freqmon_pkg.sv
package freqmon_pkg;

  // Control states of the range monitor.
  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,  // held on reference after reset, waiting for an in-band window
    ST_FORCED  = 2'd1,  // one-window forced retry after an out-of-band result
    ST_MEASURE = 2'd2   // released, loop follows the data
  } monState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic closeWin;  // last cycle of the current window
    logic halfSel;   // reference rate select sampled with closeWin
  } fmStrobe_t;

  // Tolerance in ticks, rounded up: ceil(expected * ppm / 1e6).
  function automatic int unsigned tolTicks(input int unsigned expected,
                                           input int unsigned ppm);
    longint unsigned prod;
    prod = longint'(expected) * longint'(ppm);
    return 32'((prod + 64'd999999) / 64'd1000000);
  endfunction

endpackage

// File: rtl/freqmon_datapath.sv
module freqmon_datapath
  import freqmon_pkg::*;
#(
  parameter int unsigned WIN_LEN     = 4096,
  parameter int unsigned PPM_TOL     = 1500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refToggle,
  input  fmStrobe_t strobe,
  output logic      inBand
);

  localparam int unsigned EXP_FULL = WIN_LEN;
  localparam int unsigned EXP_HALF = WIN_LEN / 2;
  localparam int unsigned TOL_FULL = tolTicks(EXP_FULL, PPM_TOL);
  localparam int unsigned TOL_HALF = tolTicks(EXP_HALF, PPM_TOL);
  localparam int unsigned CNT_W    = $clog2(EXP_FULL + TOL_FULL + 2);

  localparam logic [CNT_W-1:0] LO_FULL = CNT_W'(EXP_FULL - TOL_FULL);
  localparam logic [CNT_W-1:0] HI_FULL = CNT_W'(EXP_FULL + TOL_FULL);
  localparam logic [CNT_W-1:0] LO_HALF = CNT_W'(EXP_HALF - TOL_HALF);
  localparam logic [CNT_W-1:0] HI_HALF = CNT_W'(EXP_HALF + TOL_HALF);

  // Synchronizer for the asynchronous reference level.
  logic [SYNC_STAGES-1:0] syncStage;
  logic                   lastLevel;
  logic                   tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage <= '0;
      lastLevel <= 1'b0;
    end else begin
      syncStage <= {syncStage[SYNC_STAGES-2:0], refToggle};
      lastLevel <= syncStage[SYNC_STAGES-1];
    end
  end

  // Either edge of the synchronized level is one reference tick.
  assign tick = syncStage[SYNC_STAGES-1] ^ lastLevel;

  // Tick counter. The running total includes the tick of the current cycle.
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] windowTotal;

  assign windowTotal = tickCnt + CNT_W'(tick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.closeWin) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= windowTotal;
    end
  end

  // Band comparison against the bounds for the selected rate.
  logic [CNT_W-1:0] bandLo;
  logic [CNT_W-1:0] bandHi;

  always_comb begin
    bandLo = strobe.halfSel ? LO_HALF : LO_FULL;
    bandHi = strobe.halfSel ? HI_HALF : HI_FULL;
    inBand = (windowTotal >= bandLo) && (windowTotal <= bandHi);
  end

endmodule

// File: rtl/freqmon_control.sv
module freqmon_control
  import freqmon_pkg::*;
#(
  parameter int unsigned WIN_LEN = 4096
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      halfRate,
  input  logic      inBand,
  output fmStrobe_t strobe,
  output logic      forceRef,
  output logic      measDone,
  output logic      windowOk
);

  localparam int unsigned     WIN_W    = $clog2(WIN_LEN);
  localparam logic [WIN_W-1:0] LAST_POS = WIN_W'(WIN_LEN - 1);

  logic [WIN_W-1:0] winPos;
  logic             closeNow;
  monState_t        state;
  monState_t        stateNext;

  assign closeNow = (winPos == LAST_POS);

  always_comb begin
    strobe.closeWin = closeNow;
    strobe.halfSel  = halfRate;
  end

  // Window position counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winPos <= '0;
    end else if (closeNow) begin
      winPos <= '0;
    end else begin
      winPos <= winPos + 1'b1;
    end
  end

  // Retry sequencing: hold, forced retry, measure.
  always_comb begin
    stateNext = state;
    unique case (state)
      ST_HOLD:    stateNext = inBand ? ST_MEASURE : ST_HOLD;
      ST_FORCED:  stateNext = ST_MEASURE;
      ST_MEASURE: stateNext = inBand ? ST_MEASURE : ST_FORCED;
      default:    stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HOLD;
      measDone <= 1'b0;
      windowOk <= 1'b0;
    end else begin
      measDone <= closeNow;
      if (closeNow) begin
        state    <= stateNext;
        windowOk <= inBand;
      end
    end
  end

  assign forceRef = (state != ST_MEASURE);

endmodule

// File: rtl/freq_range_monitor.sv
module freq_range_monitor
  import freqmon_pkg::*;
#(
  parameter int unsigned WIN_LEN     = 4096,
  parameter int unsigned PPM_TOL     = 1500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refToggle,
  input  logic halfRate,
  output logic forceRef,
  output logic measDone,
  output logic windowOk
);

  fmStrobe_t strobe;
  logic      inBand;

  freqmon_control #(
    .WIN_LEN(WIN_LEN)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .halfRate(halfRate),
    .inBand  (inBand),
    .strobe  (strobe),
    .forceRef(forceRef),
    .measDone(measDone),
    .windowOk(windowOk)
  );

  freqmon_datapath #(
    .WIN_LEN    (WIN_LEN),
    .PPM_TOL    (PPM_TOL),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .refToggle(refToggle),
    .strobe   (strobe),
    .inBand   (inBand)
  );

endmodule

// File: rtl/freq_range_monitor_chk.sv
module freq_range_monitor_chk #(
  parameter int unsigned WIN_LEN = 4096
) (
  input logic clk,
  input logic rstN,
  input logic forceRef,
  input logic measDone,
  input logic windowOk
);

  // Cycles since the last strobe or since reset.
  int unsigned gapCnt;
  logic        prevForce;
  logic        retryArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt     <= 0;
      prevForce  <= 1'b1;
      retryArmed <= 1'b0;
    end else begin
      gapCnt    <= measDone ? 1 : gapCnt + 1;
      prevForce <= forceRef;
      if (measDone) begin
        retryArmed <= forceRef && !prevForce;
      end
    end
  end

  // R2: the strobe lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    measDone |=> !measDone);

  // R2: the strobe arrives exactly one window after the previous one
  p_done_period_r2: assert property (@(posedge clk) disable iff (!rstN)
    measDone |-> (gapCnt == WIN_LEN));

  p_done_not_late_r2: assert property (@(posedge clk) disable iff (!rstN)
    !measDone |-> (gapCnt < WIN_LEN));

  // R9: outputs move only with the strobe
  p_force_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !measDone |-> $stable(forceRef));

  p_ok_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !measDone |-> $stable(windowOk));

  // R6: an in-band verdict always leaves the loop released
  p_in_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (measDone && windowOk) |-> !forceRef);

  // R7: an out-of-band verdict forces unless it closes a retry window
  p_out_force_r7: assert property (@(posedge clk) disable iff (!rstN)
    (measDone && !windowOk && !retryArmed) |-> forceRef);

  // R8: a retry window always ends released
  p_forced_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (measDone && retryArmed) |-> !forceRef);

endmodule

bind freq_range_monitor freq_range_monitor_chk #(
  .WIN_LEN(WIN_LEN)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .forceRef(forceRef),
  .measDone(measDone),
  .windowOk(windowOk)
);

// File: tb/freq_range_monitor_tb.sv
module freq_range_monitor_tb;

  localparam int WIN = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refToggle = 1'b0;
  logic halfRate = 1'b1;
  logic forceRef;
  logic measDone;
  logic windowOk;

  int tests = 0;
  int fails = 0;
  int st = 0;            // 0 hold, 1 forced retry, 2 released
  int expOk = 0;
  int expForce = 1;
  bit pendingCheck = 0;
  string forceTag = "R6";

  always #5 clk = ~clk;

  freq_range_monitor u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .refToggle(refToggle),
    .halfRate (halfRate),
    .forceRef (forceRef),
    .measDone (measDone),
    .windowOk (windowOk)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // Tick pattern: a tick every cycle (full) or every other cycle (half),
  // with a mid-window offset of dev ticks.
  function automatic bit toggleAt(int p, bit patHalf, int dev);
    if (!patHalf) return !(dev < 0 && p >= 2000 && p < 2000 - dev);
    if (p % 2 == 0) return !(dev < 0 && p >= 2000 && p < 2000 - 2 * dev);
    return (dev > 0 && p >= 2001 && p < 2001 + 2 * dev);
  endfunction

  // R4 band limits, inclusive.
  function automatic int bandOk(bit selHalf, int cnt);
    if (selHalf) return (cnt >= 2044 && cnt <= 2052) ? 1 : 0;
    return (cnt >= 4089 && cnt <= 4103) ? 1 : 0;
  endfunction

  task automatic modelReset();
    st = 0; expOk = 0; expForce = 1; pendingCheck = 0;
  endtask

  task automatic modelClose(int ok);
    case (st)
      0: begin st = ok ? 2 : 0; forceTag = "R6"; end
      1: begin st = 2; forceTag = "R8"; end
      default: begin st = ok ? 2 : 1; forceTag = "R7"; end
    endcase
    expOk = ok;
    expForce = (st != 2) ? 1 : 0;
    pendingCheck = 1;
  endtask

  task automatic runWindow(bit patHalf, bit selHalf, int dev, bit glitch,
                           bit releaseNow, int resetAt);
    for (int p = 0; p < WIN; p++) begin
      @(negedge clk);
      if (p == 0 && pendingCheck) begin
        chk("R2 strobe at close", measDone, 1);
        chk("R3,R4,R5 verdict", windowOk, expOk);
        chk({forceTag, " force after close"}, forceRef, expForce);
      end
      if (p == 2000) begin
        chk("R2 no strobe mid-window", measDone, 0);
        chk("R9 force steady", forceRef, expForce);
        chk("R9 verdict steady", windowOk, expOk);
      end
      if (p == WIN - 1) chk("R2 no strobe before close", measDone, 0);
      if (p == resetAt) begin
        rstN = 1'b0;
        refToggle = 1'b0;
        #1;
        chk("R10 force on reset", forceRef, 1);
        chk("R10 strobe on reset", measDone, 0);
        chk("R10 verdict on reset", windowOk, 0);
        modelReset();
        return;
      end
      if (p == 0 && releaseNow) rstN = 1'b1;
      halfRate = (glitch && p >= 100 && p < 3000) ? !selHalf : selHalf;
      if (toggleAt(p, patHalf, dev)) refToggle = ~refToggle;
    end
    modelClose(bandOk(selHalf, (patHalf ? 2048 : 4096) + dev));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    report();
    $finish;
  end

  initial begin
    int dev;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    chk("R1 force in reset", forceRef, 1);
    chk("R1 strobe in reset", measDone, 0);
    chk("R1 verdict in reset", windowOk, 0);

    // Phase A: half-rate edges, retry sequencing, select timing.
    runWindow(1, 1,    0, 0, 1, -1);   // in band: leave hold (R6)
    runWindow(1, 1,    4, 0, 0, -1);   // 2052 in (R4)
    runWindow(1, 1,    5, 0, 0, -1);   // 2053 out: force (R7)
    runWindow(1, 1,    0, 0, 0, -1);   // retry ends released (R8)
    runWindow(1, 1,   -4, 0, 0, -1);   // 2044 in
    runWindow(1, 1,   -5, 0, 0, -1);   // 2043 out: force
    runWindow(1, 1,  -30, 0, 0, -1);   // out but retry releases (R8)
    runWindow(1, 1,    0, 1, 0, -1);   // select glitch mid-window (R5)
    runWindow(0, 0,    0, 0, 0, -1);   // switch to full rate
    runWindow(0, 0,   -7, 0, 0, -1);   // 4089 in
    runWindow(0, 0,   -8, 0, 0, -1);   // 4088 out: force
    runWindow(0, 0, -100, 0, 0, -1);   // retry releases
    runWindow(0, 0, -100, 0, 0, -1);   // out again: force
    runWindow(0, 0,    0, 0, 0, -1);
    runWindow(0, 1,    0, 0, 0, -1);   // full ticks, half select: out (R5)
    runWindow(0, 0,    0, 0, 0, -1);
    runWindow(1, 0,    0, 0, 0, -1);   // half ticks, full select: out (R5)
    runWindow(1, 1,    0, 0, 0, -1);
    runWindow(0, 0,    0, 0, 0, -1);

    // Random offsets near the band edges.
    for (int i = 0; i < 6; i++) begin
      dev = -int'($urandom % 13);
      runWindow(0, 0, dev, 0, 0, -1);
    end
    runWindow(1, 1, 0, 0, 0, -1);
    for (int i = 0; i < 6; i++) begin
      dev = int'($urandom % 19) - 9;
      runWindow(1, 1, dev, 0, 0, -1);
    end

    // Mid-window reset (R10), then hold behaviour after reset (R6).
    runWindow(1, 1, 0, 0, 0, 1500);
    repeat (2) @(negedge clk);
    chk("R1 force held in reset", forceRef, 1);
    runWindow(1, 1, -20, 0, 1, -1);    // out: stays held
    runWindow(1, 1,  10, 0, 0, -1);    // out: stays held
    runWindow(1, 1,   0, 0, 0, -1);    // in: released
    runWindow(1, 1, -20, 0, 0, -1);    // out: force (R7)
    @(negedge clk);
    chk("R2 final strobe", measDone, 1);
    chk("R3,R4 final verdict", windowOk, expOk);
    chk({forceTag, " final force"}, forceRef, expForce);

    report();
    $finish;
  end

endmodule